// File: doc/BRIEF.md
# Virtual Address Window Check and Fault Capture

This block stands on the path of every memory access, between the address generator and an external TLB lookup. It takes a virtual address, the kind of access (load, store or fetch), the privilege level, a strap that says whether translation hardware exists, a probe flag and the TLB lookup result. Within the same cycle it returns either a physical address or a fault with a cause code.

Two fixed address windows are decided before the TLB result is consulted. In supervisor mode, a high window maps to itself. In user mode, a wider high window is refused outright. Every other address takes the TLB result: a hit with the right permission is translated, and anything else faults.

When a real fault is raised on a valid access, three capture registers are written on the clock edge: the faulting address, a flag that tells data from instruction accesses, and a page-table-entry pointer. The pointer carries the faulting page number, so a refill handler can index the page table without further arithmetic. A probe access only reports success or failure and leaves all three registers alone.

Top module: `addr_window_xlate`

## Requirements
- R1: When `mmu_strap` is 0, every valid access gives `xl_ok`=1 and `xl_paddr` equal to `acc_vaddr`. It never faults and never writes a capture register.
- R2: In supervisor mode (`acc_super`=1) with `mmu_strap`=1, an address at or above 0xC0000000 gives `xl_ok`=1 and `xl_paddr`=`acc_vaddr` whatever the TLB result. Supervisor addresses below that value go through the TLB.
- R3: In user mode with `mmu_strap`=1, an address at or above 0x80000000 faults with cause 9 and writes the whole address into `badva_q`. It leaves `pteaddr_q` and `tlbmisc_d_q` unchanged.
- R4: On a TLB hit with the needed permission, `xl_paddr` is {`tlb_pfn`, `acc_vaddr`[11:0]} (4 KiB pages).
- R5: `acc_kind` is encoded 0 = load, 1 = store, 2 = fetch. `tlb_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. On a hit without the needed bit, the access faults with cause 13 (load), 14 (store) or 15 (fetch).
- R6: A TLB miss (`tlb_hit`=0) on the translated path faults with cause 12, whatever `tlb_perm` holds.
- R7: A miss or permission fault sets `tlbmisc_d_q` to 1 for a load or store and clears it to 0 for a fetch.
- R8: A miss or permission fault loads `badva_q` with the full address. It loads `pteaddr_q`[21:2] with `acc_vaddr`[31:12] and `pteaddr_q`[1:0] with 0. `pteaddr_q`[31:22] always keeps the base field (0x2A5 by default).
- R9: With `acc_probe`=1, a failing access gives `xl_ok`=0, `xl_fault`=0 and `xl_cause`=0, and writes no capture register.
- R10: With `acc_valid`=0, `xl_ok` and `xl_fault` are 0 and no capture register changes.
- R11: After reset, `badva_q` is 0, `tlbmisc_d_q` is 0, and `pteaddr_q` holds the base field with a zero page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_super | input | 1 | 1 = supervisor mode |
| mmu_strap | input | 1 | 1 = translation hardware present |
| acc_probe | input | 1 | Probe only: report, do not fault |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_pfn | input | 20 | Physical page number of the hit entry |
| tlb_perm | input | 3 | Entry permissions {exec, write, read} |
| xl_ok | output | 1 | Access translated and allowed |
| xl_paddr | output | 32 | Physical address, 0 when not ok |
| xl_fault | output | 1 | Fault raised |
| xl_cause | output | 5 | Cause code, 0 when no fault |
| badva_q | output | 32 | Captured faulting address |
| pteaddr_q | output | 32 | Page-table pointer: base, page number, 2 zero bits |
| tlbmisc_d_q | output | 1 | 1 = last TLB fault was a data access |

## Verification
The assertions assume that `acc_kind` never carries the unused value 3. They also assume that every input is steady around the sampling edge, so a fault seen in one cycle can be related to the register values in the next. The bench uses only the three defined kinds. It changes inputs on the falling edge and holds them through the rising edge that captures a fault. It checks the capture registers only after that edge, and before the next access is applied.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [4:0] {
      CAUSE_NONE    = 5'd0,
      CAUSE_SUPER   = 5'd9,
      CAUSE_MISS    = 5'd12,
      CAUSE_PERM_RD = 5'd13,
      CAUSE_PERM_WR = 5'd14,
      CAUSE_PERM_EX = 5'd15
   } cause_e;

   typedef enum logic [1:0] {
      WIN_IDENTITY = 2'd0,
      WIN_TLB      = 2'd1,
      WIN_DENY     = 2'd2
   } win_e;

endpackage

// File: rtl/xlate_at_or_above.sv
module xlate_at_or_above #(
   parameter int unsigned       W    = 32,
   parameter logic [W-1:0]      BASE = 32'h8000_0000
) (
   input  logic [W-1:0] addr_i,
   output logic         above_o
);

   function automatic bit top_ones(input logic [W-1:0] b);
      logic [W-1:0] nb;
      nb = ~b;
      return (b != '0) && ((nb & (nb + 1'b1)) == '0);
   endfunction

   localparam bit PREFIX_FORM = top_ones(BASE);

   generate
      if (PREFIX_FORM) begin : g_prefix
         // base is all ones above a bit and zeros below: a mask test suffices
         assign above_o = ((addr_i & BASE) == BASE);
      end else begin : g_magnitude
         assign above_o = (addr_i >= BASE);
      end
   endgenerate

endmodule

// File: rtl/xlate_win_dec.sv
module xlate_win_dec
   import xlate_pkg::*;
#(
   parameter int unsigned          ADDR_W           = 32,
   parameter logic [ADDR_W-1:0]    KERN_BYPASS_BASE = 32'hC000_0000,
   parameter logic [ADDR_W-1:0]    USER_TOP         = 32'h8000_0000
) (
   input  logic [ADDR_W-1:0] vaddr_i,
   input  logic              super_i,
   input  logic              mmu_on_i,
   output win_e              win_o
);

   logic in_kern;
   logic in_user_forbidden;

   xlate_at_or_above #(.W(ADDR_W), .BASE(KERN_BYPASS_BASE)) u_kern (
      .addr_i  (vaddr_i),
      .above_o (in_kern)
   );

   xlate_at_or_above #(.W(ADDR_W), .BASE(USER_TOP)) u_user (
      .addr_i  (vaddr_i),
      .above_o (in_user_forbidden)
   );

   always_comb begin
      if (!mmu_on_i)
         win_o = WIN_IDENTITY;
      else if (super_i && in_kern)
         win_o = WIN_IDENTITY;
      else if (!super_i && in_user_forbidden)
         win_o = WIN_DENY;
      else
         win_o = WIN_TLB;
   end

endmodule

// File: rtl/xlate_perm_chk.sv
module xlate_perm_chk
   import xlate_pkg::*;
(
   input  logic [1:0] kind_i,
   input  logic       hit_i,
   input  logic [2:0] perm_i,
   output logic       granted_o,
   output cause_e     cause_o
);

   logic   need_bit;
   cause_e deny_cause;

   always_comb begin
      case (kind_i)
         ACC_LOAD: begin
            need_bit   = perm_i[0];
            deny_cause = CAUSE_PERM_RD;
         end
         ACC_STORE: begin
            need_bit   = perm_i[1];
            deny_cause = CAUSE_PERM_WR;
         end
         default: begin
            need_bit   = perm_i[2];
            deny_cause = CAUSE_PERM_EX;
         end
      endcase
   end

   always_comb begin
      granted_o = hit_i && need_bit;
      if (!hit_i)
         cause_o = CAUSE_MISS;
      else if (!need_bit)
         cause_o = deny_cause;
      else
         cause_o = CAUSE_NONE;
   end

endmodule

// File: rtl/xlate_fault_regs.sv
module xlate_fault_regs #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned PAGE_BITS     = 12,
   parameter int unsigned VPN_LSB       = 2,
   parameter int unsigned PTE_BASE_INIT = 'h2A5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en_i,
   input  logic              cap_tlb_i,
   input  logic              cap_data_i,
   input  logic [ADDR_W-1:0] cap_vaddr_i,
   output logic [ADDR_W-1:0] badva_o,
   output logic [ADDR_W-1:0] pteaddr_o,
   output logic              dflag_o
);

   localparam int unsigned VPN_W  = ADDR_W - PAGE_BITS;
   localparam int unsigned BASE_W = ADDR_W - VPN_W - VPN_LSB;
   localparam logic [BASE_W-1:0] BASE_FIELD = BASE_W'(PTE_BASE_INIT);

   logic [VPN_W-1:0] vpn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badva_o <= '0;
         vpn_q   <= '0;
         dflag_o <= 1'b0;
      end else if (cap_en_i) begin
         badva_o <= cap_vaddr_i;
         if (cap_tlb_i) begin
            vpn_q   <= cap_vaddr_i[ADDR_W-1:PAGE_BITS];
            dflag_o <= cap_data_i;
         end
      end
   end

   generate
      if (VPN_LSB == 0) begin : g_no_pad
         assign pteaddr_o = {BASE_FIELD, vpn_q};
      end else begin : g_pad
         assign pteaddr_o = {BASE_FIELD, vpn_q, {VPN_LSB{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
   import xlate_pkg::*;
#(
   parameter int unsigned          ADDR_W           = 32,
   parameter int unsigned          PAGE_BITS        = 12,
   parameter logic [ADDR_W-1:0]    KERN_BYPASS_BASE = 32'hC000_0000,
   parameter logic [ADDR_W-1:0]    USER_TOP         = 32'h8000_0000,
   parameter int unsigned          VPN_LSB          = 2,
   parameter int unsigned          PTE_BASE_INIT    = 'h2A5,
   localparam int unsigned         PFN_W            = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_vaddr,
   input  logic [1:0]        acc_kind,
   input  logic              acc_super,
   input  logic              mmu_strap,
   input  logic              acc_probe,
   input  logic              tlb_hit,
   input  logic [PFN_W-1:0]  tlb_pfn,
   input  logic [2:0]        tlb_perm,
   output logic              xl_ok,
   output logic [ADDR_W-1:0] xl_paddr,
   output logic              xl_fault,
   output logic [4:0]        xl_cause,
   output logic [ADDR_W-1:0] badva_q,
   output logic [ADDR_W-1:0] pteaddr_q,
   output logic              tlbmisc_d_q
);

   localparam int unsigned BASE_W = ADDR_W - PFN_W - VPN_LSB;

   generate
      if (PAGE_BITS == 0 || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("PAGE_BITS must lie between 1 and ADDR_W-1");
      end
      if (PFN_W + VPN_LSB >= ADDR_W) begin : g_bad_pte
         $error("page number and pad leave no room for the table base");
      end
      if (PTE_BASE_INIT >= (1 << BASE_W)) begin : g_bad_base
         $error("PTE_BASE_INIT does not fit the base field");
      end
      if (USER_TOP > KERN_BYPASS_BASE) begin : g_bad_windows
         $error("user limit must not lie above the supervisor bypass window");
      end
   endgenerate

   win_e   win;
   logic   granted;
   cause_e tlb_cause;
   logic   ok_raw;
   cause_e cause_raw;

   xlate_win_dec #(
      .ADDR_W           (ADDR_W),
      .KERN_BYPASS_BASE (KERN_BYPASS_BASE),
      .USER_TOP         (USER_TOP)
   ) u_win (
      .vaddr_i  (acc_vaddr),
      .super_i  (acc_super),
      .mmu_on_i (mmu_strap),
      .win_o    (win)
   );

   xlate_perm_chk u_perm (
      .kind_i    (acc_kind),
      .hit_i     (tlb_hit),
      .perm_i    (tlb_perm),
      .granted_o (granted),
      .cause_o   (tlb_cause)
   );

   always_comb begin
      case (win)
         WIN_IDENTITY: begin
            ok_raw    = 1'b1;
            cause_raw = CAUSE_NONE;
         end
         WIN_DENY: begin
            ok_raw    = 1'b0;
            cause_raw = CAUSE_SUPER;
         end
         default: begin
            ok_raw    = granted;
            cause_raw = tlb_cause;
         end
      endcase
   end

   always_comb begin
      xl_ok    = acc_valid && ok_raw;
      xl_fault = acc_valid && !ok_raw && !acc_probe;
      xl_cause = xl_fault ? cause_raw : CAUSE_NONE;
      if (!xl_ok)
         xl_paddr = '0;
      else if (win == WIN_TLB)
         xl_paddr = {tlb_pfn, acc_vaddr[PAGE_BITS-1:0]};
      else
         xl_paddr = acc_vaddr;
   end

   xlate_fault_regs #(
      .ADDR_W        (ADDR_W),
      .PAGE_BITS     (PAGE_BITS),
      .VPN_LSB       (VPN_LSB),
      .PTE_BASE_INIT (PTE_BASE_INIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en_i    (xl_fault),
      .cap_tlb_i   (win == WIN_TLB),
      .cap_data_i  (acc_kind != ACC_FETCH),
      .cap_vaddr_i (acc_vaddr),
      .badva_o     (badva_q),
      .pteaddr_o   (pteaddr_q),
      .dflag_o     (tlbmisc_d_q)
   );

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
   import xlate_pkg::*;
#(
   parameter int unsigned          ADDR_W           = 32,
   parameter int unsigned          PAGE_BITS        = 12,
   parameter logic [ADDR_W-1:0]    KERN_BYPASS_BASE = 32'hC000_0000,
   parameter logic [ADDR_W-1:0]    USER_TOP         = 32'h8000_0000,
   parameter int unsigned          VPN_LSB          = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_vaddr,
   input logic [1:0]        acc_kind,
   input logic              acc_super,
   input logic              mmu_strap,
   input logic              acc_probe,
   input logic              xl_ok,
   input logic [ADDR_W-1:0] xl_paddr,
   input logic              xl_fault,
   input logic [4:0]        xl_cause,
   input logic [ADDR_W-1:0] badva_q,
   input logic [ADDR_W-1:0] pteaddr_q,
   input logic              tlbmisc_d_q
);

   localparam int unsigned BASE_W = VPN_LSB + PAGE_BITS - VPN_LSB - VPN_LSB + VPN_LSB - PAGE_BITS + ADDR_W - (ADDR_W - PAGE_BITS) - VPN_LSB;

   // R1
   nommu_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !mmu_strap |-> xl_ok && !xl_fault && xl_paddr == acc_vaddr);

   // R2
   kern_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && mmu_strap && acc_super && acc_vaddr >= KERN_BYPASS_BASE
      |-> xl_ok && xl_paddr == acc_vaddr);

   // R3
   user_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && mmu_strap && !acc_super && acc_vaddr >= USER_TOP && !acc_probe
      |-> xl_fault && xl_cause == CAUSE_SUPER);

   // R3
   user_deny_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_fault && xl_cause == CAUSE_SUPER |=> $stable(pteaddr_q) && $stable(tlbmisc_d_q));

   // R4
   page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_ok |-> xl_paddr[PAGE_BITS-1:0] == acc_vaddr[PAGE_BITS-1:0]);

   // R5
   ok_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xl_ok && xl_fault));

   // R7
   data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_fault && xl_cause != CAUSE_SUPER
      |=> tlbmisc_d_q == ($past(acc_kind) != ACC_FETCH));

   // R8
   badva_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_fault |=> badva_q == $past(acc_vaddr));

   // R8
   pte_base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(pteaddr_q[ADDR_W-1 -: BASE_W]));

   // R9
   probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_probe |-> !xl_fault && xl_cause == CAUSE_NONE);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !xl_ok && !xl_fault);

   // R10
   idle_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(badva_q) && $stable(pteaddr_q) && $stable(tlbmisc_d_q));

endmodule

bind addr_window_xlate xlate_chk #(
   .ADDR_W           (ADDR_W),
   .PAGE_BITS        (PAGE_BITS),
   .KERN_BYPASS_BASE (KERN_BYPASS_BASE),
   .USER_TOP         (USER_TOP),
   .VPN_LSB          (VPN_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_vaddr   (acc_vaddr),
   .acc_kind    (acc_kind),
   .acc_super   (acc_super),
   .mmu_strap   (mmu_strap),
   .acc_probe   (acc_probe),
   .xl_ok       (xl_ok),
   .xl_paddr    (xl_paddr),
   .xl_fault    (xl_fault),
   .xl_cause    (xl_cause),
   .badva_q     (badva_q),
   .pteaddr_q   (pteaddr_q),
   .tlbmisc_d_q (tlbmisc_d_q)
);

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;

   localparam logic [31:0] PTE_BASE_EXP = 32'h2A5 << 22;
   localparam logic [1:0]  K_LD = 2'd0;
   localparam logic [1:0]  K_ST = 2'd1;
   localparam logic [1:0]  K_FE = 2'd2;
   localparam logic [31:0] C_NONE = 0, C_SUPER = 9, C_MISS = 12;
   localparam logic [31:0] C_PRD = 13, C_PWR = 14, C_PEX = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_vaddr = '0;
   logic [1:0]  acc_kind = '0;
   logic        acc_super = 1'b0;
   logic        mmu_strap = 1'b0;
   logic        acc_probe = 1'b0;
   logic        tlb_hit = 1'b0;
   logic [19:0] tlb_pfn = '0;
   logic [2:0]  tlb_perm = '0;
   logic        xl_ok;
   logic [31:0] xl_paddr;
   logic        xl_fault;
   logic [4:0]  xl_cause;
   logic [31:0] badva_q;
   logic [31:0] pteaddr_q;
   logic        tlbmisc_d_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   addr_window_xlate dut (
      .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_vaddr (acc_vaddr),
      .acc_kind (acc_kind), .acc_super (acc_super), .mmu_strap (mmu_strap),
      .acc_probe (acc_probe), .tlb_hit (tlb_hit), .tlb_pfn (tlb_pfn),
      .tlb_perm (tlb_perm), .xl_ok (xl_ok), .xl_paddr (xl_paddr),
      .xl_fault (xl_fault), .xl_cause (xl_cause), .badva_q (badva_q),
      .pteaddr_q (pteaddr_q), .tlbmisc_d_q (tlbmisc_d_q)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pte_exp(input logic [31:0] va);
      return PTE_BASE_EXP | ((va >> 10) & 32'h003F_FFFC);
   endfunction

   // apply on a falling edge, let combinational outputs settle
   task automatic put(input logic v, input logic [31:0] va, input logic [1:0] k,
                      input logic sup, input logic mmu, input logic prb,
                      input logic hit, input logic [19:0] pfn, input logic [2:0] perm);
      @(negedge clk);
      acc_valid = v; acc_vaddr = va; acc_kind = k; acc_super = sup;
      mmu_strap = mmu; acc_probe = prb; tlb_hit = hit; tlb_pfn = pfn; tlb_perm = perm;
      #2;
   endtask

   // let the rising edge capture, then sample on the following falling edge
   task automatic settle;
      @(negedge clk);
      acc_valid = 1'b0; acc_probe = 1'b0;
   endtask

   task automatic t_reset;
      chk("R11", "badva", badva_q, 32'h0);
      chk("R11", "pteaddr", pteaddr_q, PTE_BASE_EXP);
      chk("R11", "dflag", {31'b0, tlbmisc_d_q}, 32'h0);
      chk("R10", "ok idle", {31'b0, xl_ok}, 32'h0);
   endtask

   task automatic t_nommu;
      put(1, 32'hDEAD_BEEF, K_ST, 0, 0, 0, 0, 20'h0, 3'b000);
      chk("R1", "ok", {31'b0, xl_ok}, 32'h1);
      chk("R1", "paddr", xl_paddr, 32'hDEAD_BEEF);
      chk("R1", "fault", {31'b0, xl_fault}, 32'h0);
      settle();
      chk("R1", "badva untouched", badva_q, 32'h0);
   endtask

   task automatic t_kern;
      put(1, 32'hC000_0000, K_LD, 1, 1, 0, 0, 20'h0, 3'b000);
      chk("R2", "bypass ok", {31'b0, xl_ok}, 32'h1);
      chk("R2", "bypass paddr", xl_paddr, 32'hC000_0000);
      put(1, 32'hC012_3456, K_FE, 1, 1, 0, 0, 20'h0, 3'b000);
      chk("R2", "bypass paddr2", xl_paddr, 32'hC012_3456);
      put(1, 32'h9000_1234, K_LD, 1, 1, 0, 1, 20'h00ABC, 3'b001);
      chk("R2", "super below window via tlb", xl_paddr, 32'h00AB_C234);
      put(1, 32'hBFFF_FFFF, K_LD, 1, 1, 0, 0, 20'h0, 3'b111);
      chk("R2", "super below window miss", {27'b0, xl_cause}, C_MISS);
      settle();
      chk("R8", "badva after super miss", badva_q, 32'hBFFF_FFFF);
   endtask

   task automatic t_hit;
      put(1, 32'h1234_5678, K_LD, 0, 1, 0, 1, 20'h76543, 3'b001);
      chk("R4", "ok", {31'b0, xl_ok}, 32'h1);
      chk("R4", "paddr", xl_paddr, 32'h7654_3678);
      put(1, 32'h0000_0FFF, K_FE, 0, 1, 0, 1, 20'hFFFFF, 3'b100);
      chk("R4", "paddr edge", xl_paddr, 32'hFFFF_FFFF);
      settle();
   endtask

   task automatic t_perm;
      put(1, 32'h0040_3ABC, K_ST, 0, 1, 0, 1, 20'h11111, 3'b101);
      chk("R5", "store cause", {27'b0, xl_cause}, C_PWR);
      chk("R5", "store ok", {31'b0, xl_ok}, 32'h0);
      chk("R5", "store paddr", xl_paddr, 32'h0);
      settle();
      chk("R7", "store dflag", {31'b0, tlbmisc_d_q}, 32'h1);
      chk("R8", "store badva", badva_q, 32'h0040_3ABC);
      chk("R8", "store pteaddr", pteaddr_q, pte_exp(32'h0040_3ABC));
      put(1, 32'h0002_F000, K_FE, 0, 1, 0, 1, 20'h22222, 3'b011);
      chk("R5", "fetch cause", {27'b0, xl_cause}, C_PEX);
      settle();
      chk("R7", "fetch dflag", {31'b0, tlbmisc_d_q}, 32'h0);
      chk("R8", "fetch pteaddr", pteaddr_q, pte_exp(32'h0002_F000));
      put(1, 32'h7FFF_FFFC, K_LD, 0, 1, 0, 1, 20'h33333, 3'b110);
      chk("R5", "load cause", {27'b0, xl_cause}, C_PRD);
      settle();
      chk("R7", "load dflag", {31'b0, tlbmisc_d_q}, 32'h1);
      chk("R8", "load pteaddr", pteaddr_q, 32'hA95F_FFFC);
   endtask

   task automatic t_miss;
      put(1, 32'h0000_1000, K_FE, 0, 1, 0, 0, 20'h0, 3'b111);
      chk("R6", "fetch miss cause", {27'b0, xl_cause}, C_MISS);
      settle();
      chk("R7", "fetch miss dflag", {31'b0, tlbmisc_d_q}, 32'h0);
      put(1, 32'h0000_2000, K_ST, 0, 1, 0, 0, 20'h0, 3'b111);
      chk("R6", "store miss cause", {27'b0, xl_cause}, C_MISS);
      chk("R6", "store miss fault", {31'b0, xl_fault}, 32'h1);
      settle();
      chk("R7", "store miss dflag", {31'b0, tlbmisc_d_q}, 32'h1);
      chk("R8", "store miss pteaddr", pteaddr_q, pte_exp(32'h0000_2000));
   endtask

   task automatic t_deny;
      logic [31:0] pte_before;
      pte_before = pteaddr_q;
      put(1, 32'h8000_0000, K_LD, 0, 1, 0, 1, 20'h44444, 3'b111);
      chk("R3", "cause", {27'b0, xl_cause}, C_SUPER);
      chk("R3", "ok", {31'b0, xl_ok}, 32'h0);
      settle();
      chk("R3", "badva", badva_q, 32'h8000_0000);
      chk("R3", "pteaddr kept", pteaddr_q, pte_before);
      chk("R3", "dflag kept", {31'b0, tlbmisc_d_q}, 32'h1);
   endtask

   task automatic t_probe;
      logic [31:0] bv;
      logic [31:0] pv;
      bv = badva_q;
      pv = pteaddr_q;
      put(1, 32'h0000_5000, K_FE, 0, 1, 1, 0, 20'h0, 3'b000);
      chk("R9", "probe ok", {31'b0, xl_ok}, 32'h0);
      chk("R9", "probe fault", {31'b0, xl_fault}, 32'h0);
      chk("R9", "probe cause", {27'b0, xl_cause}, C_NONE);
      settle();
      chk("R9", "probe badva", badva_q, bv);
      chk("R9", "probe pteaddr", pteaddr_q, pv);
      chk("R9", "probe dflag", {31'b0, tlbmisc_d_q}, 32'h1);
      put(1, 32'hF000_0000, K_LD, 0, 1, 1, 1, 20'h0, 3'b111);
      chk("R9", "probe deny fault", {31'b0, xl_fault}, 32'h0);
      settle();
      chk("R9", "probe deny badva", badva_q, bv);
   endtask

   task automatic t_idle;
      logic [31:0] bv;
      logic [31:0] pv;
      bv = badva_q;
      pv = pteaddr_q;
      put(0, 32'h0000_9000, K_FE, 0, 1, 0, 0, 20'h0, 3'b000);
      chk("R10", "idle fault", {31'b0, xl_fault}, 32'h0);
      chk("R10", "idle ok", {31'b0, xl_ok}, 32'h0);
      settle();
      chk("R10", "idle badva", badva_q, bv);
      chk("R10", "idle pteaddr", pteaddr_q, pv);
      chk("R10", "idle dflag", {31'b0, tlbmisc_d_q}, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_nommu();
      t_kern();
      t_hit();
      t_perm();
      t_miss();
      t_deny();
      t_probe();
      t_idle();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule